// File: doc/BRIEF.md
# Command List Packet Parser

The parser walks a list of 32-bit words held in a synchronous memory and converts each packet in it into one or more masked register writes. A one-cycle `start` pulse supplies a byte address and a byte length. The parser reads the list word by word through a read port that returns data one cycle after a request. It decodes each packet and presents the resulting writes on a valid/ready port. The write port carries a register id, a data word and a 32-bit byte-lane mask.

A packet is laid out as a first parameter word, then a header word, then zero or more extra parameter words. The header holds the target id, a 4-bit lane-enable nibble, a count of extra parameters and an addressing-mode bit. Every packet begins on an 8-byte boundary. When the read pointer reaches the end of the list, a completion pulse is raised. A packet that is cut short by the end of the list is reported on a held error flag, which stays set until the next start.

Top module: `cmdlist_parser`

## Requirements
- R1: A `start` pulse seen while idle clears the low 3 bits of `buf_addr` and the low 2 bits of `buf_size`. The first read is then issued at the cleared address.
- R2: Each packet reads its first parameter word and then its header word. The first write carries id = header[15:0] and data = that parameter. Header bits [30:28] have no effect.
- R3: The write mask is built from header[19:16]. Bit k set makes byte k of the mask 0xFF, and bit k clear makes it 0x00. For example, 4'b1001 gives 0xFF0000FF.
- R4: Header[27:20] gives N, the number of extra parameter words. The packet produces 1+N writes, in list order, all with the same mask.
- R5: With header[31]=1, each later write of a packet uses the previous id plus 1, and the id wraps from 0xFFFF to 0x0000. With header[31]=0, every write of the packet uses the header id.
- R6: Before a packet is read, a word at an odd word offset from the cleared start address is skipped.
- R7: No read is issued at or beyond the cleared start address plus the cleared size.
- R8: After the last write of the list has been accepted, `done_irq` is high for exactly one cycle. A zero-length list gives the pulse with no read and no write.
- R9: If the list ends inside a packet, every write whose words were inside the list is still issued. `trunc_err` rises together with `done_irq` and holds until the next accepted `start`.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_id`, `wr_data` and `wr_mask` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin parsing a list (honoured when idle) |
| buf_addr | input | ADDR_W | Byte address of the list |
| buf_size | input | SIZE_W | Length of the list in bytes |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Byte address of the word requested |
| rd_data | input | 32 | Word returned one cycle after `rd_en` |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register write accepted when high with `wr_valid` |
| wr_id | output | ID_W | Target register id |
| wr_data | output | 32 | Write data |
| wr_mask | output | 32 | Byte-lane write mask |
| done_irq | output | 1 | One-cycle completion pulse |
| trunc_err | output | 1 | Last list ended inside a packet |

## Verification
Read requests are combinational from state, so each `rd_addr` is checked in the cycle in which it is requested. A write is checked in the cycle in which `wr_valid` and `wr_ready` are both seen high half a cycle before the accepting edge. That write is compared with the head of a queue filled by a behavioural walk of the bench memory. The completion pulse is due one edge after the last acceptance, or in the same edge when a truncated packet ends the list. At that pulse, the write queue must be empty and `trunc_err` must match. The cycle after the pulse must show it low. A stalled write is compared field by field with its value one cycle earlier.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PARAM = 3'd1,
    S_HDR   = 3'd2,
    S_DEC   = 3'd3,
    S_WR    = 3'd4,
    S_XDAT  = 3'd5
  } walk_state_e;

endpackage

// File: rtl/cmdlist_hdr_decode.sv
module cmdlist_hdr_decode #(
  parameter int ID_W  = 16,
  parameter int NIB_W = 4,
  parameter int CNT_W = 8,
  localparam int FIELD_W = ID_W + NIB_W + CNT_W
) (
  input  logic               step_bit,
  input  logic [FIELD_W-1:0] field_bits,
  output logic [ID_W-1:0]    reg_id,
  output logic [NIB_W-1:0]   lane_nib,
  output logic [CNT_W-1:0]   extra_cnt,
  output logic               step_mode
);

  assign reg_id    = field_bits[ID_W-1:0];
  assign lane_nib  = field_bits[ID_W +: NIB_W];
  assign extra_cnt = field_bits[ID_W+NIB_W +: CNT_W];
  assign step_mode = step_bit;

endmodule

// File: rtl/cmdlist_mask_expand.sv
module cmdlist_mask_expand #(
  parameter int NIB_W = 4,
  localparam int MASK_W = NIB_W * 8
) (
  input  logic [NIB_W-1:0]  lane_nib,
  output logic [MASK_W-1:0] byte_mask
);

  for (genvar lane = 0; lane < NIB_W; lane++) begin : g_lane
    assign byte_mask[lane*8 +: 8] = {8{lane_nib[lane]}};
  end

  always_comb begin
    if (!$isunknown(lane_nib)) begin
      AST_MASK_LANES: assert ($countones(byte_mask) == 8 * $countones(lane_nib)); // R3
    end
  end

endmodule

// File: rtl/cmdlist_parser.sv
module cmdlist_parser
  import cmdlist_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int ID_W   = 16,
  parameter int NIB_W  = 4,
  parameter int CNT_W  = 8,
  localparam int DATA_W  = NIB_W * 8,
  localparam int FIELD_W = ID_W + NIB_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [SIZE_W-1:0] buf_size,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ID_W-1:0]   wr_id,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_mask,
  output logic              done_irq,
  output logic              trunc_err
);

  localparam int OFF_W = SIZE_W - 2;
  localparam int CMP_W = (ADDR_W > SIZE_W) ? ADDR_W : SIZE_W;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  nw_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] param_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] mask_q;
  logic [CNT_W-1:0]  rem_q;
  logic              step_q;
  logic              irq_q;
  logic              err_q;

  logic [ID_W-1:0]   h_id;
  logic [NIB_W-1:0]  h_nib;
  logic [CNT_W-1:0]  h_cnt;
  logic              h_step;
  logic [DATA_W-1:0] h_mask;

  logic at_end;
  logic hs;

  cmdlist_hdr_decode #(
    .ID_W (ID_W),
    .NIB_W(NIB_W),
    .CNT_W(CNT_W)
  ) i_hdr (
    .step_bit  (rd_data[DATA_W-1]),
    .field_bits(rd_data[FIELD_W-1:0]),
    .reg_id    (h_id),
    .lane_nib  (h_nib),
    .extra_cnt (h_cnt),
    .step_mode (h_step)
  );

  cmdlist_mask_expand #(
    .NIB_W(NIB_W)
  ) i_mask (
    .lane_nib (h_nib),
    .byte_mask(h_mask)
  );

  assign at_end = (off_q >= nw_q);
  assign hs     = wr_valid && wr_ready;

  // Read port: the word address comes straight from the walk pointer.
  assign rd_addr = base_q + ADDR_W'({off_q, 2'b00});

  always_comb begin
    rd_en = 1'b0;
    unique case (state_q)
      S_PARAM: rd_en = !at_end && !off_q[0];
      S_HDR:   rd_en = !at_end;
      S_WR:    rd_en = hs && (rem_q != '0) && !at_end;
      default: rd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      base_q   <= '0;
      nw_q     <= '0;
      off_q    <= '0;
      param_q  <= '0;
      id_q     <= '0;
      mask_q   <= '0;
      rem_q    <= '0;
      step_q   <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      wr_valid <= 1'b0;
      wr_id    <= '0;
      wr_data  <= '0;
      wr_mask  <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            base_q  <= buf_addr & ~ADDR_W'(7);
            nw_q    <= OFF_W'(buf_size >> 2);
            off_q   <= '0;
            err_q   <= 1'b0;
            state_q <= S_PARAM;
          end
        end
        S_PARAM: begin
          if (at_end) begin
            irq_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (off_q[0]) begin
            off_q <= off_q + 1'b1;
          end else begin
            off_q   <= off_q + 1'b1;
            state_q <= S_HDR;
          end
        end
        S_HDR: begin
          param_q <= rd_data;
          if (at_end) begin
            err_q   <= 1'b1;
            irq_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            off_q   <= off_q + 1'b1;
            state_q <= S_DEC;
          end
        end
        S_DEC: begin
          id_q     <= h_id;
          mask_q   <= h_mask;
          rem_q    <= h_cnt;
          step_q   <= h_step;
          wr_valid <= 1'b1;
          wr_id    <= h_id;
          wr_data  <= param_q;
          wr_mask  <= h_mask;
          state_q  <= S_WR;
        end
        S_WR: begin
          if (hs) begin
            wr_valid <= 1'b0;
            if (rem_q == '0) begin
              state_q <= S_PARAM;
            end else if (at_end) begin
              err_q   <= 1'b1;
              irq_q   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              off_q   <= off_q + 1'b1;
              rem_q   <= rem_q - 1'b1;
              id_q    <= id_q + ID_W'(step_q);
              state_q <= S_XDAT;
            end
          end
        end
        S_XDAT: begin
          wr_valid <= 1'b1;
          wr_data  <= rd_data;
          wr_id    <= id_q;
          wr_mask  <= mask_q;
          state_q  <= S_WR;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_irq  = irq_q;
  assign trunc_err = err_q;

  logic [ADDR_W-1:0] rd_span;
  assign rd_span = rd_addr - base_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_id) && $stable(wr_data) && $stable(wr_mask))); // R10
  AST_RD_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (CMP_W'(rd_span >> 2) < CMP_W'(nw_q))); // R7
  AST_PKT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state_q == S_PARAM) |-> (rd_addr[2:0] == 3'b000)); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq); // R8
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(trunc_err) |-> done_irq); // R9

endmodule

// File: tb/test_cmdlist_parser.sv
module test_cmdlist_parser;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] buf_addr = '0;
  logic [31:0] buf_size = '0;
  logic        rd_en;
  logic [31:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_id;
  logic [31:0] wr_data;
  logic [31:0] wr_mask;
  logic        done_irq;
  logic        trunc_err;

  cmdlist_parser i_cmdlist_parser (
    .clk(clk), .rst(rst), .start(start), .buf_addr(buf_addr), .buf_size(buf_size),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_id(wr_id), .wr_data(wr_data),
    .wr_mask(wr_mask), .done_irq(done_irq), .trunc_err(trunc_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:255];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[9:2]];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [15:0] q_id[$];
  logic [31:0] q_data[$];
  logic [31:0] q_mask[$];
  logic        exp_err;
  logic [31:0] exp_base;
  logic [31:0] exp_bytes;
  int          ready_mode = 0;
  bit          got_irq = 0;
  bit          first_rd = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input bit inc, input int cnt, input logic [3:0] nib, input logic [15:0] id);
    return {inc, 3'b101, 8'(cnt), nib, id};
  endfunction

  function automatic logic [31:0] nib_mask(input logic [3:0] nib);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (nib[k]) m = m | (32'hFF << (8*k));
    return m;
  endfunction

  task automatic build_expect(input logic [31:0] addr, input logic [31:0] size);
    int b, nw, off, cnt;
    logic [31:0] param, h, m;
    logic [15:0] id;
    b = int'(addr >> 3) * 2;
    nw = int'(size >> 2);
    off = 0;
    exp_err = 0;
    exp_base = addr & ~32'd7;
    exp_bytes = size & ~32'd3;
    while (off < nw) begin
      if (off % 2 == 1) begin off++; continue; end
      param = mem[b+off]; off++;
      if (off >= nw) begin exp_err = 1; break; end
      h = mem[b+off]; off++;
      id = h[15:0]; m = nib_mask(h[19:16]); cnt = int'(h[27:20]);
      q_id.push_back(id); q_data.push_back(param); q_mask.push_back(m);
      for (int i = 0; i < cnt; i++) begin
        if (off >= nw) begin exp_err = 1; break; end
        if (h[31]) id = id + 16'd1;
        q_id.push_back(id); q_data.push_back(mem[b+off]); q_mask.push_back(m);
        off++;
      end
      if (exp_err) break;
    end
  endtask

  // Checker: drives ready, then inspects the values that meet the next edge.
  logic        p_v = 0, p_r = 0, p_irq = 0;
  logic [15:0] p_id;
  logic [31:0] p_data, p_mask;
  always begin
    @(negedge clk);
    cyc++;
    if (!rst) begin
      wr_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 != 1);
      #1;
      if (p_v && !p_r)
        check(wr_valid && wr_id == p_id && wr_data == p_data && wr_mask == p_mask,
              "R10 stalled write changed", {wr_id, wr_data}, {p_id, p_data});
      if (rd_en) begin
        check(rd_addr >= exp_base && rd_addr < exp_base + exp_bytes, "R7 read out of list",
              rd_addr, exp_base);
        if (first_rd) begin
          check(rd_addr == exp_base, "R1 first read address", rd_addr, exp_base);
          first_rd = 0;
        end
      end
      if (wr_valid && wr_ready) begin
        if (q_id.size() == 0) begin
          check(0, "R4 unexpected extra write", {wr_id, wr_data}, 0);
        end else begin
          check(wr_id == q_id[0], "R2/R5 write id", wr_id, q_id[0]);
          check(wr_data == q_data[0], "R2/R4/R6 write data", wr_data, q_data[0]);
          check(wr_mask == q_mask[0], "R3 write mask", wr_mask, q_mask[0]);
          void'(q_id.pop_front()); void'(q_data.pop_front()); void'(q_mask.pop_front());
        end
      end
      if (p_irq) check(!done_irq, "R8 irq longer than one cycle", done_irq, 0);
      if (done_irq) begin
        check(q_id.size() == 0, "R8 irq before all writes", q_id.size(), 0);
        check(trunc_err == exp_err, "R9 truncation flag", trunc_err, exp_err);
        got_irq = 1;
      end
      p_v = wr_valid; p_r = wr_ready; p_id = wr_id; p_data = wr_data; p_mask = wr_mask;
      p_irq = done_irq;
    end
  end

  task automatic run(input logic [31:0] addr, input logic [31:0] size, input int mode, input bit chk_hold);
    int t;
    if (chk_hold) check(trunc_err == exp_err, "R9 flag held until start", trunc_err, exp_err);
    build_expect(addr, size);
    ready_mode = mode;
    got_irq = 0;
    first_rd = (exp_bytes != 0);
    @(negedge clk);
    start = 1; buf_addr = addr; buf_size = size;
    @(negedge clk);
    start = 0;
    t = 0;
    while (!got_irq && t < 2000) begin @(negedge clk); t++; end
    check(got_irq, "R8 completion pulse seen", got_irq, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hBAD0_0000 | i;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(!wr_valid && !done_irq && !rd_en && !trunc_err, "R8 reset state",
          {wr_valid, done_irq, rd_en, trunc_err}, 0);

    // R2 R3: two single-write packets, full mask, reserved header bits set
    mem[0] = 32'h1111_1111; mem[1] = hdr(0, 0, 4'hF, 16'h0010);
    mem[2] = 32'h2222_2222; mem[3] = hdr(0, 0, 4'hF, 16'h0020);
    run(32'h000, 32'd16, 0, 0);

    // R4 R5 R6: stepping bursts, odd-length packet forces a skipped pad word
    mem[16] = 32'hA0; mem[17] = hdr(1, 2, 4'b0011, 16'h0100); mem[18] = 32'hA1; mem[19] = 32'hA2;
    mem[20] = 32'hB0; mem[21] = hdr(1, 1, 4'b1100, 16'h0200); mem[22] = 32'hB1; mem[23] = 32'hDEAD;
    mem[24] = 32'hC0; mem[25] = hdr(0, 0, 4'hF, 16'h0300);
    run(32'h040, 32'd40, 1, 1);

    // R3 R5: fixed-id burst, lane pattern 1001
    mem[32] = 32'h5; mem[33] = hdr(0, 3, 4'b1001, 16'h0055);
    mem[34] = 32'h6; mem[35] = 32'h7; mem[36] = 32'h8;
    run(32'h080, 32'd20, 1, 1);

    // R5: id wraps from FFFF
    mem[48] = 32'hE0; mem[49] = hdr(1, 2, 4'hF, 16'hFFFF); mem[50] = 32'hE1; mem[51] = 32'hE2;
    run(32'h0C0, 32'd16, 0, 1);

    // R1 R7: unaligned address and size, word beyond end must not be read
    mem[64] = 32'h77; mem[65] = hdr(0, 0, 4'b0101, 16'h0007);
    mem[66] = 32'h88; mem[67] = hdr(0, 0, 4'b0010, 16'h0008);
    mem[68] = hdr(1, 9, 4'hF, 16'h0999);
    run(32'h105, 32'h13, 1, 1);

    // R8: zero-length list
    run(32'h140, 32'd3, 0, 1);

    // R9: burst cut by the end of the list
    mem[96] = 32'hF0; mem[97] = hdr(1, 5, 4'hF, 16'h0040); mem[98] = 32'hF1; mem[99] = 32'hF2;
    run(32'h180, 32'd16, 1, 1);

    // R9: second packet has no header inside the list
    mem[112] = 32'h31; mem[113] = hdr(0, 0, 4'b0001, 16'h0031); mem[114] = 32'h32;
    mem[115] = hdr(0, 0, 4'hF, 16'h0032);
    run(32'h1C0, 32'd12, 0, 1);

    // R9: flag cleared by next start of a clean list
    run(32'h000, 32'd16, 1, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule